// File: doc/BRIEF.md
# UART Host Register Bank with Byte FIFOs

This block is the host-side register file of a 16550-style serial port. A bus master reaches it through a byte-wide window of eight offsets. Bit 7 of the line control register is a divisor-select latch. While it is clear, offset 0 is the data port: a write queues a byte for sending and a read takes the oldest received byte. Offset 1 then holds the interrupt enable bits. While the latch is set, offsets 0 and 1 hold the low and high bytes of the 16-bit baud divisor instead.

The serial shifters and the baud generator sit outside the block. The transmit shifter sees the head of a 16-entry transmit FIFO as `tx_data`, qualified by `tx_valid`, and takes it with a one-cycle `tx_take` pulse. The receive shifter delivers each assembled character with a one-cycle `rx_push` pulse. The character is masked to the programmed word length and queued in a 16-entry receive FIFO.

A write-only FIFO control register shares offset 2 with the read-only interrupt identification register. The control register enables the FIFOs, clears them and selects the receive trigger level. A prioritised interrupt output summarises line errors, received data and an empty transmit queue.

Top module: `uart_regbank`

## Requirements
- R1: After reset, the line control register reads 0x03 and the divisor output is 0x0001. Offset 1 reads 0x00, offset 2 reads 0x01 and the line status register at offset 5 reads 0x20. `irq` and `tx_valid` are 0.
- R2: With line control bit 7 set, offsets 0 and 1 read and write divisor bits 7:0 and 15:8, and `divisor` shows the result. These accesses leave the FIFOs and the interrupt enables unchanged.
- R3: With line control bit 7 clear, a write to offset 0 appends a byte to the transmit FIFO. `tx_data` shows the oldest byte while `tx_valid` is 1, and `tx_take` removes it. With the FIFOs enabled the queue holds 16 bytes, and a write to a full queue is dropped.
- R4: With line control bit 7 clear, a read of offset 0 returns and removes the oldest received byte, in arrival order. A read while the queue is empty returns 0x00.
- R5: A received character is stored with the bits above the word length forced to 0. Line control bits 1:0 select the length: 00, 01, 10 and 11 mean 5, 6, 7 and 8 bits.
- R6: The line status register has bit 0 = receive data ready, bit 1 = overrun and bit 5 = transmit queue empty. When `rx_push` arrives while the receive queue is full and no read removes a byte in that cycle, the byte is discarded and overrun is set. Reading offset 5 clears overrun.
- R7: When `rx_push` arrives in the same cycle as a host read of a full receive queue, the new byte is accepted at the tail and no overrun is flagged.
- R8: A write to offset 2 sets the FIFO mode. Bit 0 enables the FIFOs; while it is clear each queue holds one byte. Bit 1 empties the receive queue and bit 2 empties the transmit queue, both on that write only. A write that changes bit 0 empties both queues.
- R9: Bits 7:6 of the offset 2 write select the receive trigger level. The codes 00, 01, 10 and 11 mean 1, 4, 8 and 14 characters. With the FIFOs disabled the level is 1.
- R10: Reads of offset 2 return the interrupt identification code. Bits 7:6 are both 1 while the FIFOs are enabled, and bit 0 = 1 means nothing is pending. Otherwise the code is 0x_6 for overrun, 0x_4 for received data at or above the trigger level and 0x_2 for transmit empty, in that priority. `irq` is 1 exactly while something is pending.
- R11: The transmit-empty interrupt becomes pending when the transmit queue becomes empty, or when its enable is newly set while the queue is empty. It is cleared by a write to offset 0 or by a read of offset 2 that reports it.
- R12: Offset 1 bits 0, 1 and 2 enable the received-data, transmit-empty and overrun interrupts; a source whose enable is 0 leaves `irq` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_data | output | 8 | Oldest queued transmit byte |
| tx_take | input | 1 | Transmit shifter takes the head byte |
| rx_push | input | 1 | Receive shifter delivers a character |
| rx_byte | input | 8 | Received character, bit 0 first received |
| divisor | output | 16 | Baud divisor for the external generator |
| char_len | output | 2 | Word length code for the shifters |

## Verification
A host read of offset 0 and a character delivery from the receive shifter can land in the same cycle. Near a full receive queue they decide whether a byte is lost. The bench fills the queue to 16, then raises `rx_push` in the same cycle as a data read. It checks that the read returns the oldest byte and that overrun stays clear. It then drains the queue and expects the 15 remaining bytes followed by the new one. A separate case delivers the byte with no read in that cycle, and the bench expects overrun and the byte's loss.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_take,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  output logic [15:0] divisor,
  output logic [1:0]  char_len
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    lcr;
  logic [2:0]    ier;
  logic [15:0]   div_q;
  logic          fifo_en, ovr, thre_ip, tx_empty_q;
  logic [1:0]    trig_sel;
  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, cap, trig_lvl;
  logic [2:0]    iir_id;
  logic [7:0]    iir, lsr;

  wire dlab    = lcr[7];
  wire wr      = bus_sel & bus_we;
  wire rd      = bus_sel & ~bus_we;
  wire wr_thr  = wr & (bus_addr == 3'd0) & ~dlab;
  wire rd_rbr  = rd & (bus_addr == 3'd0) & ~dlab;
  wire wr_ier  = wr & (bus_addr == 3'd1) & ~dlab;
  wire wr_fcr  = wr & (bus_addr == 3'd2);
  wire rd_iir  = rd & (bus_addr == 3'd2);
  wire rd_lsr  = rd & (bus_addr == 3'd5);
  wire div_wr  = wr & dlab & (bus_addr[2:1] == 2'b00);
  wire en_chg  = wr_fcr & (bus_wdata[0] != fifo_en);
  wire tx_clr  = wr_fcr & (bus_wdata[2] | en_chg);
  wire rx_clr  = wr_fcr & (bus_wdata[1] | en_chg);

  assign cap = fifo_en ? CW'(DEPTH) : CW'(1);
  wire tx_empty = (tx_cnt == '0);
  wire rx_ready = (rx_cnt != '0);
  wire tx_full  = (tx_cnt >= cap);
  wire rx_full  = (rx_cnt >= cap);
  wire tx_push  = wr_thr & ~tx_full;
  wire tx_pop   = tx_take & ~tx_empty;
  wire rx_pop   = rd_rbr & rx_ready;
  wire rx_ok    = rx_push & (~rx_full | rx_pop) & ~rx_clr;
  wire rx_lost  = rx_push & rx_full & ~rx_pop & ~rx_clr;
  wire [7:0] rx_masked = rx_byte & (8'hFF >> (2'd3 - lcr[1:0]));

  assign tx_valid = ~tx_empty;
  assign tx_data  = tx_mem[tx_rp];
  assign divisor  = div_q;
  assign char_len = lcr[1:0];

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;
    if (rx_ok)   rx_mem[rx_wp] <= rx_masked;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_ok)  rx_wp <= rx_wp + 1'b1;
      if (rx_pop) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_ok) - CW'(rx_pop);
    end
  end

  always_comb begin
    case (trig_sel)
      2'd0:    trig_lvl = CW'(1);
      2'd1:    trig_lvl = CW'(4);
      2'd2:    trig_lvl = CW'(8);
      default: trig_lvl = CW'(14);
    endcase
    if (!fifo_en) trig_lvl = CW'(1);
  end

  wire ls_p = ier[2] & ovr;
  wire rd_p = ier[0] & rx_ready & (rx_cnt >= trig_lvl);
  wire th_p = ier[1] & thre_ip;
  assign iir_id = ls_p ? 3'b011 : rd_p ? 3'b010 : th_p ? 3'b001 : 3'b000;
  assign iir = {{2{fifo_en}}, 2'b00, iir_id, ~(ls_p | rd_p | th_p)};
  assign lsr = {2'b00, tx_empty, 3'b000, ovr, rx_ready};
  assign irq = ls_p | rd_p | th_p;

  wire thre_set = (tx_empty & ~tx_empty_q) | (wr_ier & bus_wdata[1] & ~ier[1] & tx_empty);
  wire thre_clr = wr_thr | (rd_iir & (iir_id == 3'b001));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr <= 8'h03; ier <= '0; div_q <= 16'h0001;
      fifo_en <= 1'b0; trig_sel <= '0;
      ovr <= 1'b0; thre_ip <= 1'b0; tx_empty_q <= 1'b1;
    end else begin
      tx_empty_q <= tx_empty;
      if (wr && bus_addr == 3'd3) lcr <= bus_wdata;
      if (div_wr && !bus_addr[0]) div_q[7:0]  <= bus_wdata;
      if (div_wr &&  bus_addr[0]) div_q[15:8] <= bus_wdata;
      if (wr_ier) ier <= bus_wdata[2:0];
      if (wr_fcr) begin
        fifo_en  <= bus_wdata[0];
        trig_sel <= bus_wdata[7:6];
      end
      if (rx_lost)     ovr <= 1'b1;
      else if (rd_lsr) ovr <= 1'b0;
      if (thre_set)      thre_ip <= 1'b1;
      else if (thre_clr) thre_ip <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = dlab ? div_q[7:0] : (rx_ready ? rx_mem[rx_rp] : 8'h00);
      3'd1:    bus_rdata = dlab ? div_q[15:8] : {5'b00000, ier};
      3'd2:    bus_rdata = iir;
      3'd3:    bus_rdata = lcr;
      3'd5:    bus_rdata = lsr;
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int DEPTH = 16,
  parameter int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_take,
  input logic          tx_valid,
  input logic          tx_push,
  input logic          tx_clr,
  input logic          rx_lost,
  input logic          rx_clr,
  input logic          ovr,
  input logic          irq,
  input logic [7:0]    iir,
  input logic          div_wr,
  input logic [15:0]   divisor
);
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(DEPTH)); // R3
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= CW'(DEPTH)); // R4
  AST_TX_POP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take && tx_valid && !tx_push && !tx_clr |=> tx_cnt == $past(tx_cnt) - CW'(1)); // R3
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n) rx_lost |=> ovr); // R6
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) rx_clr |=> rx_cnt == '0); // R8
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n) irq == !iir[0]); // R10
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !div_wr |=> $stable(divisor)); // R2
endmodule

bind uart_regbank uart_regbank_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_take(tx_take), .tx_valid(tx_valid), .tx_push(tx_push), .tx_clr(tx_clr),
  .rx_lost(rx_lost), .rx_clr(rx_clr), .ovr(ovr), .irq(irq), .iir(iir),
  .div_wr(div_wr), .divisor(divisor)
);

// File: tb/uart_regbank_tb_top.sv
module uart_regbank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0, tx_take = 0, rx_push = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, rx_byte = 0;
  logic [7:0] bus_rdata, tx_data;
  logic irq, tx_valid;
  logic [15:0] divisor;
  logic [1:0] char_len;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_take(tx_take), .rx_push(rx_push), .rx_byte(rx_byte),
    .divisor(divisor), .char_len(char_len)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_sel = 0;
  endtask

  task automatic rdchk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, {8'h0, v}, {8'h0, exp});
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_byte = b;
    @(posedge clk); #1 rx_push = 0;
  endtask

  task automatic take();
    @(negedge clk); tx_take = 1;
    @(posedge clk); #1 tx_take = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 tx_valid", {15'h0, tx_valid}, 16'h0);
    chk("R1 divisor", divisor, 16'h0001);
    rdchk("R1 lcr", 3'd3, 8'h03);
    rdchk("R1 ier", 3'd1, 8'h00);
    rdchk("R1 iir", 3'd2, 8'h01);
    rdchk("R1 lsr", 3'd5, 8'h20);
  endtask

  task automatic t_divisor();
    wr(3'd3, 8'h83); wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    @(negedge clk); chk("R2 divisor out", divisor, 16'h1234);
    rdchk("R2 div low", 3'd0, 8'h34);
    rdchk("R2 div high", 3'd1, 8'h12);
    wr(3'd3, 8'h03);
    rdchk("R2 ier untouched", 3'd1, 8'h00);
    rdchk("R2 fifo untouched", 3'd5, 8'h20);
    chk("R2 tx untouched", {15'h0, tx_valid}, 16'h0);
  endtask

  task automatic t_tx();
    wr(3'd2, 8'h01);
    for (int i = 0; i < 17; i++) wr(3'd0, 8'h40 + 8'(i));
    rdchk("R3 thr not empty", 3'd5, 8'h00);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R3 tx_valid", {15'h0, tx_valid}, 16'h1);
      chk("R3 tx order", {8'h0, tx_data}, {8'h0, 8'h40 + 8'(i)});
      take();
    end
    @(negedge clk); chk("R3 17th dropped", {15'h0, tx_valid}, 16'h0);
    rdchk("R6 thr empty bit", 3'd5, 8'h20);
  endtask

  task automatic t_rx();
    push(8'hA5); push(8'h3C); push(8'hF0);
    rdchk("R6 data ready", 3'd5, 8'h21);
    rdchk("R4 first", 3'd0, 8'hA5);
    rdchk("R4 second", 3'd0, 8'h3C);
    rdchk("R4 third", 3'd0, 8'hF0);
    rdchk("R4 empty read", 3'd0, 8'h00);
    rdchk("R4 ready cleared", 3'd5, 8'h20);
  endtask

  task automatic t_pad();
    wr(3'd3, 8'h00); push(8'hFF);
    @(negedge clk); chk("R5 char_len", {14'h0, char_len}, 16'h0);
    rdchk("R5 five bits", 3'd0, 8'h1F);
    wr(3'd3, 8'h02); push(8'hFF);
    rdchk("R5 seven bits", 3'd0, 8'h7F);
    wr(3'd3, 8'h03); push(8'hC3);
    rdchk("R5 eight bits", 3'd0, 8'hC3);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
    push(8'hEE);
    rdchk("R6 overrun set", 3'd5, 8'h23);
    rdchk("R6 overrun cleared by read", 3'd5, 8'h21);
    for (int i = 0; i < 16; i++) rdchk("R6 kept bytes", 3'd0, 8'h10 + 8'(i));
    rdchk("R6 lost byte absent", 3'd0, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    for (int i = 0; i < 16; i++) push(8'h60 + 8'(i));
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = 3'd0; rx_push = 1; rx_byte = 8'h99;
    #1 v = bus_rdata;
    @(posedge clk); #1 bus_sel = 0; rx_push = 0;
    chk("R7 read oldest", {8'h0, v}, 16'h0060);
    rdchk("R7 no overrun", 3'd5, 8'h21);
    for (int i = 1; i < 16; i++) rdchk("R7 order", 3'd0, 8'h60 + 8'(i));
    rdchk("R7 new byte at tail", 3'd0, 8'h99);
    rdchk("R7 empty", 3'd0, 8'h00);
  endtask

  task automatic t_trig();
    int lvl [4] = '{1, 4, 8, 14};
    wr(3'd1, 8'h01);
    for (int e = 0; e < 4; e++) begin
      wr(3'd2, {2'(e), 6'h01});
      for (int i = 0; i < lvl[e] - 1; i++) push(8'(i));
      @(negedge clk); chk("R9 below level", {15'h0, irq}, 16'h0);
      rdchk("R9 iir idle", 3'd2, 8'hC1);
      push(8'hAA);
      @(negedge clk); chk("R9 at level", {15'h0, irq}, 16'h1);
      rdchk("R10 rx code", 3'd2, 8'hC4);
      wr(3'd2, {2'(e), 6'h03});
      @(negedge clk); chk("R8 rx clear", {15'h0, irq}, 16'h0);
    end
  endtask

  task automatic t_prio();
    wr(3'd1, 8'h00); wr(3'd2, 8'h01);
    for (int i = 0; i < 17; i++) push(8'(i));
    @(negedge clk); chk("R12 masked irq", {15'h0, irq}, 16'h0);
    rdchk("R12 masked iir", 3'd2, 8'hC1);
    wr(3'd1, 8'h07);
    rdchk("R10 overrun first", 3'd2, 8'hC6);
    rdchk("R6 lsr", 3'd5, 8'h23);
    rdchk("R10 rx next", 3'd2, 8'hC4);
    for (int i = 0; i < 16; i++) rdchk("R10 drain", 3'd0, 8'(i));
    rdchk("R11 thre reported", 3'd2, 8'hC2);
    rdchk("R11 cleared by iir read", 3'd2, 8'hC1);
    @(negedge clk); chk("R10 irq low", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_thre();
    wr(3'd1, 8'h00); wr(3'd1, 8'h02);
    @(negedge clk); chk("R11 set on enable", {15'h0, irq}, 16'h1);
    rdchk("R11 code", 3'd2, 8'hC2);
    wr(1'b0 ? 3'd1 : 3'd0, 8'h55);
    @(negedge clk); chk("R3 head", {8'h0, tx_data}, 16'h0055);
    rdchk("R11 cleared by write", 3'd2, 8'hC1);
    take();
    repeat (2) @(negedge clk);
    chk("R11 set on empty", {15'h0, irq}, 16'h1);
    wr(3'd1, 8'h00);
    @(negedge clk); chk("R12 disabled", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_fcr();
    push(8'h01); push(8'h02); push(8'h03);
    wr(3'd0, 8'hA1); wr(3'd0, 8'hA2);
    wr(3'd2, 8'h07);
    rdchk("R8 both cleared", 3'd5, 8'h20);
    chk("R8 tx cleared", {15'h0, tx_valid}, 16'h0);
    push(8'h11);
    rdchk("R8 self clearing", 3'd0, 8'h11);
    push(8'h31); wr(3'd2, 8'h00);
    rdchk("R8 enable change clears", 3'd5, 8'h20);
    push(8'h21); push(8'h22);
    rdchk("R8 one-byte mode overrun", 3'd5, 8'h23);
    rdchk("R8 one-byte kept", 3'd0, 8'h21);
    rdchk("R8 one-byte empty", 3'd0, 8'h00);
    rdchk("R10 iir no fifo bits", 3'd2, 8'h01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset(); t_divisor(); t_tx(); t_rx(); t_pad(); t_overrun();
    t_collide(); t_trig(); t_prio(); t_thre(); t_fcr();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule